// File: doc/BRIEF.md
# Cascadable Three-Channel Down-Counting Timer

This block holds three identical down counters behind a small 32-bit register bus. Each channel has a reload value, a current count that software can read, and a control word. The control word selects the enable, the reload behaviour, the clock divide ratio and the interrupt behaviour. Software loads a channel, enables it, and then sees an interrupt each time the count runs out. The interrupt can be masked. It can be presented as a one-cycle pulse or as a level that stays high until software clears the pending flag.

A shared cascade register links the channels into one wider counter. Channel 0 can drive channel 1, or channel 0 can drive channel 1, which drives channel 2. A linked channel counts expiries of the channel before it instead of ticks from its own divider, and only the last channel of the cascade raises its pending flag. Register writes take effect at the clock edge where the bus write is presented. Reads are combinational from the address.

Top module: `cascade_timer`

## Requirements
- R1: After reset every register reads zero and all `irq` bits are low.
- R2: Byte addresses decode on `bus_addr[5:2]`. Channel n (n = 0..2) starts at 0x10*n, with the reload value at +0x0, the current count at +0x4 and the control word at +0x8. The cascade mode (2 bits) is at 0x30. The reload value, the control word and the cascade mode read back what was written. The current count ignores writes.
- R3: Control bits 6:4 pick the divide ratio. Codes 0..7 give 1, 4, 8, 16, 32, 64, 128 and 256. With ratio D, the first decrement after enabling happens D cycles after the enabling write, and each further decrement follows D cycles later.
- R4: Setting control bit 8 (enable) from 0 copies the reload value L into the count. Each tick then decrements the count. A tick taken while the count is zero is an expiry, so the first expiry comes at tick L+1.
- R5: When control bit 7 is 1 (periodic), an expiry reloads L, so the channel expires every L+1 ticks.
- R6: When control bit 7 is 0 (free-running), an expiry wraps the count to 0xFFFFFFFF and counting goes on.
- R7: Control bit 2 is the pending flag, and an expiry sets it. A control write with bit 2 = 0 clears it. A write with bit 2 = 1 leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag is set.
- R8: With control bit 1 = 0 (edge), `irq[n]` goes high for exactly one cycle, in the cycle after the edge that sets the flag.
- R9: With control bit 1 = 1 (level), `irq[n]` follows the pending flag. `irq[n]` stays low whenever control bit 3 (interrupt enable) is 0.
- R10: In cascade mode 1, channel 1 decrements only on an expiry of channel 0. Channel 0 never sets its pending flag.
- R11: In cascade mode 2, channel 2 decrements only on an expiry of channel 1, and only channel 2 sets a pending flag. Mode 3 behaves like mode 0, with all channels independent.
- R12: Clearing the enable freezes the count and resets the divider. A reload write while disabled also sets the count. A reload write while enabled leaves the count alone.
- R13: The offsets 0x0C, 0x1C and 0x2C read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe; a write happens when it and bus_wr are high at an edge |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-channel interrupt outputs |

## Verification
Random runs on channel 0 draw a reload value, a divide code, a reload mode and a wait length. The count and the level interrupt are then compared with a bench formula. This separates errors in tick spacing from errors in expiry, reload and wrap. Directed cases cover the rest:
- large divide codes, to expose an off-by-one in the divider;
- a short edge-mode period, to show whether the pulse lasts one cycle;
- flag writes of 0 and 1, for the clear rule;
- mask-off runs, for the gating;
- each cascade mode, checked one cycle before and at the expected expiry, to tell a correct link from a channel still counting on its own divider;
- disable, reload and unused-offset accesses, for freeze and decode.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

  // divider counter width, enough for the largest ratio
  localparam int PSC_CW  = 8;
  localparam int CTL_LSB = 1;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [2:0] psc;
    logic       irq_en;
    logic       pend;
    logic       level;
  } tctl_t;

  localparam int CTL_W = $bits(tctl_t);

  typedef enum logic [1:0] {
    SUB_LOAD = 2'd0,
    SUB_CUR  = 2'd1,
    SUB_CTL  = 2'd2,
    SUB_NONE = 2'd3
  } sub_e;

  // divide ratio for a code: 1, then powers of two from 4 upward
  function automatic logic [PSC_CW:0] psc_ratio(input logic [2:0] code);
    if (code == 3'd0) return (PSC_CW+1)'(1);
    return (PSC_CW+1)'(1) << (int'(code) + 1);
  endfunction

endpackage

// File: rtl/cascade_timer_psc.sv
module cascade_timer_psc
  import cascade_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);

  logic [PSC_CW-1:0] cnt;
  logic [PSC_CW:0]   last;

  assign last = psc_ratio(code) - 1'b1;
  // >= keeps a mid-run code change from stalling the divider
  assign tick = run && ({1'b0, cnt} >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R12: a stopped channel restarts its divider from zero
  assert_psc_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

endmodule

// File: rtl/cascade_timer_chan.sv
module cascade_timer_chan
  import cascade_timer_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic          ctl_we,
  input  logic [TW-1:0] wdata,
  input  logic          chained,
  input  logic          up_expire,
  input  logic          flag_ok,
  output logic [TW-1:0] load_q,
  output logic [TW-1:0] cur_q,
  output tctl_t         ctl_q,
  output logic          expire,
  output logic          set_evt,
  output logic          irq
);

  tctl_t ctl_wr, ctl_d;
  logic  tick, step, start, pulse_q;

  function automatic logic [TW-1:0] next_count(input logic [TW-1:0] cur,
                                               input logic [TW-1:0] rel,
                                               input logic          per);
    if (cur != '0) return cur - 1'b1;
    return per ? rel : '1;
  endfunction

  cascade_timer_psc u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctl_q.en),
    .code (ctl_q.psc),
    .tick (tick)
  );

  assign ctl_wr  = tctl_t'(wdata[CTL_LSB +: CTL_W]);
  assign step    = ctl_q.en && (chained ? up_expire : tick);
  assign expire  = step && (cur_q == '0);
  assign set_evt = expire && flag_ok;
  assign start   = ctl_we && !ctl_q.en && ctl_wr.en;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d      = ctl_wr;
      ctl_d.pend = ctl_q.pend & ctl_wr.pend;
    end
    if (set_evt) ctl_d.pend = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      cur_q   <= '0;
      ctl_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      pulse_q <= set_evt;
      if (ld_we) load_q <= wdata;
      if (start)                   cur_q <= load_q;
      else if (ld_we && !ctl_q.en) cur_q <= wdata;
      else if (step)               cur_q <= next_count(cur_q, load_q, ctl_q.periodic);
    end
  end

  assign irq = ctl_q.irq_en && (ctl_q.level ? ctl_q.pend : pulse_q);

  assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !ld_we && !ctl_we) |=> $stable(cur_q));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl_q.periodic) |=> cur_q == $past(load_q));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl_q.periodic) |=> cur_q == '1);
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ctl_q.pend);
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wr.pend && !set_evt) |=> !ctl_q.pend);
  assert_edge_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_q.level) |-> $past(set_evt));

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 32,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [TW-1:0] bus_wdata,
  output logic [TW-1:0] bus_rdata,
  output logic [NCH-1:0] irq
);

  localparam int MW = $clog2(NCH);
  localparam int BW = AW - 4;

  logic [BW-1:0]   blk;
  sub_e            sub;
  logic            wr_go, chain_hit;
  logic [MW-1:0]   chain_q;
  int              eff_mode;
  logic [TW-1:0]   load_w  [NCH];
  logic [TW-1:0]   cur_w   [NCH];
  tctl_t           ctl_w   [NCH];
  logic [NCH-1:0]  exp_w, set_w, chained_w, up_w;
  wire             unused_lsb = ^bus_addr[1:0];

  assign blk       = bus_addr[AW-1:4];
  assign sub       = sub_e'(bus_addr[3:2]);
  assign wr_go     = bus_sel && bus_wr;
  assign chain_hit = (int'(blk) == NCH) && (sub == SUB_LOAD);

  always_comb eff_mode = (int'(chain_q) < NCH) ? int'(chain_q) : 0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  chain_q <= '0;
    else if (wr_go && chain_hit) chain_q <= bus_wdata[MW-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_head
      assign up_w[i] = 1'b0;
    end else begin : g_link
      assign up_w[i] = exp_w[i-1];
    end
    assign chained_w[i] = (i > 0) && (i <= eff_mode);

    cascade_timer_chan #(.TW(TW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_we    (wr_go && (int'(blk) == i) && (sub == SUB_LOAD)),
      .ctl_we   (wr_go && (int'(blk) == i) && (sub == SUB_CTL)),
      .wdata    (bus_wdata),
      .chained  (chained_w[i]),
      .up_expire(up_w[i]),
      .flag_ok  (i >= eff_mode),
      .load_q   (load_w[i]),
      .cur_q    (cur_w[i]),
      .ctl_q    (ctl_w[i]),
      .expire   (exp_w[i]),
      .set_evt  (set_w[i]),
      .irq      (irq[i])
    );

    if (i + 1 < NCH) begin : g_chk
      // R10: a channel feeding a cascade never raises its own flag
      assert_feeder_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chained_w[i+1] |-> !set_w[i]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(blk) == i) begin
        case (sub)
          SUB_LOAD: bus_rdata = load_w[i];
          SUB_CUR:  bus_rdata = cur_w[i];
          SUB_CTL:  bus_rdata[CTL_LSB +: CTL_W] = ctl_w[i];
          default:  bus_rdata = '0;
        endcase
      end
    end
    if (chain_hit) bus_rdata[MW-1:0] = chain_q;
  end

  // R11: an out-of-range cascade code links nothing
  assert_mode_fallback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chain_q) >= NCH) |-> chained_w == '0);
  // R13: a write to a gap offset leaves all channel state unchanged
  assert_gap_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sub == SUB_NONE && !chain_hit && ctl_w[0].en == 1'b0)
      |=> $stable(load_w[0]));

endmodule

// File: tb/cascade_timer_test.sv
`timescale 1ns/1ps
module cascade_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v, v2;

  always #2.5 clk = ~clk;

  cascade_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int div_of(input int code);
    return (code == 0) ? 1 : (4 << (code - 1));
  endfunction

  function automatic logic [31:0] ctl(input int en, input int per, input int code,
                                      input int msk, input int pnd, input int lvl);
    return 32'((en << 8) | (per << 7) | (code << 4) | (msk << 3) | (pnd << 2) | (lvl << 1));
  endfunction

  function automatic logic [31:0] cur_model(input int L, input int D, input int m, input int per);
    int s = m / D;
    if (s <= L) return 32'(L - s);
    if (per != 0) return 32'(L - ((s - L - 1) % (L + 1)));
    return 32'hFFFF_FFFF - 32'(s - L - 1);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    wr(6'h08, 0); wr(6'h18, 0); wr(6'h28, 0); wr(6'h30, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    rd(6'h00, v); chk("R1 load0", v, 0);
    rd(6'h14, v); chk("R1 cur1", v, 0);
    rd(6'h28, v); chk("R1 ctl2", v, 0);
    rd(6'h30, v); chk("R1 cascade", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 readback and read-only count
    wr(6'h20, 32'hA5A5_0F0F); rd(6'h20, v); chk("R2 load2", v, 32'hA5A5_0F0F);
    wr(6'h28, ctl(0, 1, 5, 1, 0, 1)); rd(6'h28, v); chk("R2 ctl2", v, ctl(0, 1, 5, 1, 0, 1));
    wr(6'h24, 32'h1234); rd(6'h24, v); chk("R2 cur ro", v, 32'hA5A5_0F0F);
    wr(6'h30, 2); rd(6'h30, v); chk("R2 cascade", v, 2);
    quiet();

    // R13 gap offsets
    wr(6'h00, 32'd77); wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, v); chk("R13 gap0", v, 0);
    rd(6'h1C, v); chk("R13 gap1", v, 0);
    rd(6'h00, v); chk("R13 load kept", v, 77);
    rd(6'h08, v); chk("R13 ctl kept", v, 0);

    // R3 divider ratios
    wr(6'h00, 3); wr(6'h08, ctl(1, 1, 7, 0, 0, 0));
    waitn(255); rd(6'h04, v); chk("R3 div256 early", v, 3);
    waitn(1);   rd(6'h04, v); chk("R3 div256 step", v, 2);
    wr(6'h08, 0); wr(6'h00, 9); wr(6'h08, ctl(1, 1, 3, 0, 0, 0));
    waitn(15); rd(6'h04, v); chk("R3 div16 early", v, 9);
    waitn(1);  rd(6'h04, v); chk("R3 div16 step", v, 8);
    quiet();

    // R4 R5 R6 R9 random runs against the model, level irq
    for (int it = 0; it < 16; it++) begin
      int L, code, per, m, D;
      L = 1 + int'($urandom % 15);
      code = int'($urandom % 3);
      per = int'($urandom % 2);
      D = div_of(code);
      m = int'($urandom % ((L + 1) * D * 2 + 4));
      wr(6'h08, 0);
      wr(6'h00, 32'(L));
      wr(6'h08, ctl(1, per, code, 1, 0, 1));
      waitn(m);
      rd(6'h04, v);
      chk(per != 0 ? "R5 R4 count" : "R6 R4 count", v, cur_model(L, D, m, per));
      chk("R9 level irq", 32'(irq[0]), ((m / D) >= L + 1) ? 1 : 0);
    end
    quiet();

    // R6 directed wrap
    wr(6'h00, 2); wr(6'h08, ctl(1, 0, 0, 0, 0, 0));
    waitn(3); rd(6'h04, v); chk("R6 wrap", v, 32'hFFFF_FFFF);
    quiet();

    // R8 edge pulse, R7 flag
    wr(6'h00, 3); wr(6'h08, ctl(1, 1, 0, 1, 0, 0));
    waitn(3); chk("R8 before", 32'(irq[0]), 0);
    waitn(1); chk("R8 pulse", 32'(irq[0]), 1);
    rd(6'h08, v); chk("R7 set", 32'(v[2]), 1);
    waitn(1); chk("R8 one cycle", 32'(irq[0]), 0);
    wr(6'h08, ctl(0, 1, 0, 1, 1, 0));
    rd(6'h08, v); chk("R7 write1 keeps", 32'(v[2]), 1);
    wr(6'h08, ctl(0, 1, 0, 1, 0, 0));
    rd(6'h08, v); chk("R7 write0 clears", 32'(v[2]), 0);

    // R9 mask gating
    wr(6'h00, 1); wr(6'h08, ctl(1, 1, 0, 0, 0, 1));
    waitn(4); rd(6'h08, v);
    chk("R9 pend", 32'(v[2]), 1);
    chk("R9 masked", 32'(irq[0]), 0);
    wr(6'h08, ctl(1, 1, 0, 1, 1, 1));
    chk("R9 unmasked", 32'(irq[0]), 1);
    quiet();

    // R12 reload write while enabled, freeze, divider reset
    wr(6'h00, 5); wr(6'h08, ctl(1, 1, 7, 0, 0, 0));
    wr(6'h00, 9); rd(6'h04, v); chk("R12 load enabled", v, 5);
    wr(6'h08, 0); wr(6'h00, 5); wr(6'h08, ctl(1, 1, 2, 0, 0, 0));
    waitn(5); wr(6'h08, ctl(0, 1, 2, 0, 0, 0));
    rd(6'h04, v); waitn(10); rd(6'h04, v2); chk("R12 freeze", v2, v);
    wr(6'h00, 6); rd(6'h04, v); chk("R12 load disabled", v, 6);
    wr(6'h00, 5); wr(6'h08, ctl(1, 1, 2, 0, 0, 0));
    waitn(7); rd(6'h04, v); chk("R12 divider reset", v, 5);
    waitn(1); rd(6'h04, v); chk("R12 first tick", v, 4);
    quiet();

    // R10 cascade mode 1
    wr(6'h30, 1);
    wr(6'h10, 2); wr(6'h18, ctl(1, 1, 0, 1, 0, 1));
    waitn(5); rd(6'h14, v); chk("R10 no own ticks", v, 2);
    wr(6'h00, 3); wr(6'h08, ctl(1, 1, 0, 1, 0, 1));
    waitn(4); rd(6'h14, v); chk("R10 linked step", v, 1);
    waitn(7); chk("R10 before", 32'(irq[1]), 0);
    waitn(1); chk("R10 expiry", 32'(irq[1]), 1);
    chk("R10 head quiet", 32'(irq[0]), 0);
    rd(6'h08, v); chk("R10 head flag", 32'(v[2]), 0);
    quiet();

    // R11 cascade mode 2 and mode 3
    wr(6'h30, 2);
    wr(6'h20, 1); wr(6'h28, ctl(1, 1, 0, 1, 0, 1));
    wr(6'h10, 1); wr(6'h18, ctl(1, 1, 0, 1, 0, 1));
    wr(6'h00, 1); wr(6'h08, ctl(1, 1, 0, 1, 0, 1));
    waitn(7); chk("R11 before", 32'(irq[2]), 0);
    waitn(1); chk("R11 expiry", 32'(irq[2]), 1);
    chk("R11 middle quiet", 32'(irq[1:0]), 0);
    quiet();
    wr(6'h30, 3);
    wr(6'h10, 2); wr(6'h18, ctl(1, 1, 0, 0, 0, 0));
    waitn(1); rd(6'h14, v); chk("R11 mode3 independent", v, 1);

    summary();
  end

endmodule